// File: doc/BRIEF.md
# Event context save/restore sequencer

This block moves the saved context between the processor core and the system stack when an event handler starts and when it ends. When the core accepts an event, it pulses `enter_i` with the event's class code. The sequencer then writes the status word and the return address to the stack, one word per cycle. For the four interrupt levels it also writes the link register and general registers twelve down to eight, which it reads through a small register read port. The stack pointer is held inside the block. It moves down one word before each write and up one word after each read.

A return command (`ret_i`) runs the same frame in reverse. The frame size comes from the mode field of the live status word. Each word that is read back is written straight into the register file, the status register or the program counter through dedicated write strobes. While a sequence is running, `busy_o` is high and all new commands are ignored. `done_o` pulses once when the sequence ends. A sticky flag reports when a push would place data below a configurable lower stack limit.

Top module: `evt_ctx_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ovf_o` and every memory and restore strobe are low, and `sp_o` equals the parameter `SP_RESET`.
- R2: An enter whose class code is 2, 3, 4 or 5 (the interrupt levels) pushes eight words, one per cycle, starting the cycle after acceptance. The order is: status word, return address, LR (register index 5), R12 (4), R11 (3), R10 (2), R9 (1), R8 (0). The status word and return address are the values of `cur_sr_i` and `cur_pc_i` sampled at acceptance.
- R3: An enter with any other class code pushes only the status word and then the return address.
- R4: Each push writes to address `sp-4` and leaves `sp_o` at `sp-4`. Each pop reads from address `sp` and leaves `sp_o` at `sp+4`. With no access in a cycle, `sp_o` holds.
- R5: A return reads the mode field `cur_sr_i[MODE_LSB+2:MODE_LSB]` when it is accepted. For codes 2 to 5 it pops R8, R9, R10, R11, R12, LR, return address, status word. For any other code it pops only the return address and then the status word. Each word is delivered on the matching restore strobe in the same cycle as its read.
- R6: While `busy_o` is high, `enter_i` and `ret_i` have no effect. When both are high in an idle cycle, the enter is taken.
- R7: `busy_o` stays high from the cycle after acceptance through the last access. In the following cycle `done_o` is high for exactly one cycle and `busy_o` is low.
- R8: `ovf_o` sets when a push targets an address below `sp_limit_i` (unsigned compare). A target equal to the limit does not set it. Once set, it stays set until reset.
- R9: At most one stack access (read or write) happens per cycle. No memory or restore strobe is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_i | input | 1 | Event accepted, start saving context |
| enter_cls_i | input | 3 | Class code of the accepted event |
| ret_i | input | 1 | Return-from-event command |
| cur_sr_i | input | DW | Current status word |
| cur_pc_i | input | DW | Return address to save |
| sp_limit_i | input | AW | Lowest legal stack address |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| mem_addr_o | output | AW | Stack word address (byte address) |
| mem_wdata_o | output | DW | Stack write data |
| mem_rdata_i | input | DW | Stack read data, valid in the cycle of `mem_re_o` |
| rf_raddr_o | output | 3 | Register read index (0..4 = R8..R12, 5 = LR) |
| rf_rdata_i | input | DW | Register read data, same cycle |
| rf_we_o | output | 1 | Register restore strobe |
| rf_waddr_o | output | 3 | Register restore index |
| rf_wdata_o | output | DW | Register restore data |
| sr_we_o | output | 1 | Status register restore strobe |
| sr_wdata_o | output | DW | Restored status word |
| pc_we_o | output | 1 | Program counter restore strobe |
| pc_wdata_o | output | DW | Restored return address |
| sp_o | output | AW | Current system stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ovf_o | output | 1 | Sticky stack-limit violation |

## Verification
The embedded properties check several things on every cycle:
- the one-word pointer step for each access, and that the pointer holds when there is no access;
- the single-access rule and the quiet idle state;
- that an open sequence cannot be restarted, and that enter beats return;
- that the first write carries the status sampled at acceptance, and the first read uses the current pointer;
- the single-cycle done pulse, and that the overflow flag stays set.

Only the bench's scenarios can show that a complete frame is right. That means the word order and addresses for each class, that a return brings back exactly the pushed values after the sources have changed, that short frames never touch the register file, and that the overflow flag rises at the exact limit crossing.

// File: rtl/evt_ctx_pkg.sv
package evt_ctx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_POP  = 2'd2
  } seq_state_e;

  localparam int SLOT_W    = 3;
  localparam int REG_IDX_W = 3;
  localparam int MODE_W    = 3;

  // Slot numbering follows push order: 0 status, 1 return address,
  // 2 LR, 3 R12 ... 7 R8.
  localparam logic [SLOT_W-1:0] SLOT_SR    = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_PC    = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_GPR0  = 3'd2;
  localparam logic [SLOT_W-1:0] LAST_LONG  = 3'd7;
  localparam logic [SLOT_W-1:0] LAST_SHORT = 3'd1;

  localparam logic [MODE_W-1:0] IRQ_CODE_LO = 3'd2;
  localparam logic [MODE_W-1:0] IRQ_CODE_HI = 3'd5;

  // Interrupt-level classes carry the extended frame.
  function automatic logic saves_gprs(input logic [MODE_W-1:0] code);
    return (code >= IRQ_CODE_LO) && (code <= IRQ_CODE_HI);
  endfunction

  function automatic logic [SLOT_W-1:0] last_step(input logic long_f);
    return long_f ? LAST_LONG : LAST_SHORT;
  endfunction

  // Pops walk the slots backwards from the last one pushed.
  function automatic logic [SLOT_W-1:0] step_to_slot(input seq_state_e st,
                                                      input logic [SLOT_W-1:0] step,
                                                      input logic long_f);
    if (st == SEQ_POP) return last_step(long_f) - step;
    return step;
  endfunction

  // Slot 2 is LR (index 5) down to slot 7 which is R8 (index 0).
  function automatic logic [REG_IDX_W-1:0] slot_to_reg(input logic [SLOT_W-1:0] slot);
    return REG_IDX_W'(3'd7 - slot);
  endfunction

endpackage

// File: rtl/evt_frame_ctl.sv
module evt_frame_ctl
  import evt_ctx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enter_i,
  input  logic [MODE_W-1:0]   enter_cls_i,
  input  logic                ret_i,
  input  logic [MODE_W-1:0]   cur_mode_i,
  output seq_state_e          st_o,
  output logic [SLOT_W-1:0]   step_o,
  output logic                long_o,
  output logic                last_o,
  output logic                start_push_o,
  output logic                start_pop_o,
  output logic                done_o
);

  seq_state_e        st_q;
  logic [SLOT_W-1:0] step_q;
  logic              long_q;
  logic              done_q;

  assign start_push_o = (st_q == SEQ_IDLE) && enter_i;
  assign start_pop_o  = (st_q == SEQ_IDLE) && !enter_i && ret_i;
  assign last_o       = (st_q != SEQ_IDLE) && (step_q == last_step(long_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      step_q <= '0;
      long_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (start_push_o) begin
        st_q   <= SEQ_PUSH;
        step_q <= '0;
        long_q <= saves_gprs(enter_cls_i);
      end else if (start_pop_o) begin
        st_q   <= SEQ_POP;
        step_q <= '0;
        long_q <= saves_gprs(cur_mode_i);
      end else if (last_o) begin
        st_q   <= SEQ_IDLE;
        step_q <= '0;
      end else if (st_q != SEQ_IDLE) begin
        step_q <= step_q + SLOT_W'(1);
      end
    end
  end

  assign st_o   = st_q;
  assign step_o = step_q;
  assign long_o = long_q;
  assign done_o = done_q;

  // R6: an open sequence only advances, never restarts
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SEQ_IDLE && !last_o) |=> (st_q == $past(st_q) && step_q == $past(step_q) + SLOT_W'(1)));

  // R6: enter has priority over return in an idle cycle
  a_r6_enter_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && enter_i && ret_i) |=> (st_q == SEQ_PUSH));

  // R7: the last access is followed by done with the sequencer idle
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (done_o && st_q == SEQ_IDLE));

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/evt_sp_unit.sv
module evt_sp_unit #(
  parameter int            AW         = 32,
  parameter int            WORD_BYTES = 4,
  parameter logic [AW-1:0] SP_RESET   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] limit_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] addr_o,
  output logic          ovf_o
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  function automatic logic [AW-1:0] sp_down(input logic [AW-1:0] sp);
    return sp - STEP;
  endfunction

  function automatic logic [AW-1:0] sp_up(input logic [AW-1:0] sp);
    return sp + STEP;
  endfunction

  // True when the pre-decremented target lies below the limit; a wrap
  // through zero counts as below.
  function automatic logic below_limit(input logic [AW-1:0] sp, input logic [AW-1:0] lim);
    return {1'b0, sp} < ({1'b0, lim} + {1'b0, STEP});
  endfunction

  logic [AW-1:0] sp_q;
  logic          ovf_q;
  logic          ovf_hit;

  assign ovf_hit = push_i && below_limit(sp_q, limit_i);
  assign addr_o  = push_i ? sp_down(sp_q) : sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_RESET;
      ovf_q <= 1'b0;
    end else begin
      if (push_i)     sp_q <= sp_down(sp_q);
      else if (pop_i) sp_q <= sp_up(sp_q);
      if (ovf_hit)    ovf_q <= 1'b1;
    end
  end

  assign sp_o  = sp_q;
  assign ovf_o = ovf_q;

  // R4: one word down per push
  a_r4_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (sp_o == $past(sp_o) - STEP));

  // R4: one word up per pop
  a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> (sp_o == $past(sp_o) + STEP));

  // R4: pointer holds without an access
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(sp_o));

  // R9: the sequencer never requests a push and a pop together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));

  // R8: overflow is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

endmodule

// File: rtl/evt_slot_mux.sv
module evt_slot_mux
  import evt_ctx_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  seq_state_e           st_i,
  input  logic [SLOT_W-1:0]    step_i,
  input  logic                 long_i,
  input  logic [DW-1:0]        sr_cap_i,
  input  logic [DW-1:0]        pc_cap_i,
  input  logic [DW-1:0]        rf_rdata_i,
  input  logic [DW-1:0]        mem_rdata_i,
  input  logic [AW-1:0]        addr_i,
  output logic                 mem_we_o,
  output logic                 mem_re_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  output logic [REG_IDX_W-1:0] rf_raddr_o,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_waddr_o,
  output logic [DW-1:0]        rf_wdata_o,
  output logic                 sr_we_o,
  output logic [DW-1:0]        sr_wdata_o,
  output logic                 pc_we_o,
  output logic [DW-1:0]        pc_wdata_o
);

  logic [SLOT_W-1:0]    slot;
  logic                 is_push;
  logic                 is_pop;
  logic                 gpr_slot;
  logic [REG_IDX_W-1:0] reg_idx;

  always_comb begin
    slot     = step_to_slot(st_i, step_i, long_i);
    is_push  = (st_i == SEQ_PUSH);
    is_pop   = (st_i == SEQ_POP);
    gpr_slot = (slot >= SLOT_GPR0);
    reg_idx  = gpr_slot ? slot_to_reg(slot) : '0;

    mem_we_o   = is_push;
    mem_re_o   = is_pop;
    mem_addr_o = (is_push || is_pop) ? addr_i : '0;

    rf_raddr_o  = is_push ? reg_idx : '0;
    mem_wdata_o = '0;
    if (is_push) begin
      case (slot)
        SLOT_SR: mem_wdata_o = sr_cap_i;
        SLOT_PC: mem_wdata_o = pc_cap_i;
        default: mem_wdata_o = rf_rdata_i;
      endcase
    end

    rf_we_o    = is_pop && gpr_slot;
    rf_waddr_o = is_pop ? reg_idx : '0;
    rf_wdata_o = is_pop ? mem_rdata_i : '0;
    sr_we_o    = is_pop && (slot == SLOT_SR);
    sr_wdata_o = is_pop ? mem_rdata_i : '0;
    pc_we_o    = is_pop && (slot == SLOT_PC);
    pc_wdata_o = is_pop ? mem_rdata_i : '0;
  end

endmodule

// File: rtl/evt_ctx_seq.sv
module evt_ctx_seq
  import evt_ctx_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            AW       = 32,
  parameter int            MODE_LSB = 22,
  parameter logic [AW-1:0] SP_RESET = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_i,
  input  logic [2:0]    enter_cls_i,
  input  logic          ret_i,
  input  logic [DW-1:0] cur_sr_i,
  input  logic [DW-1:0] cur_pc_i,
  input  logic [AW-1:0] sp_limit_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [2:0]    rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [2:0]    rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          sr_we_o,
  output logic [DW-1:0] sr_wdata_o,
  output logic          pc_we_o,
  output logic [DW-1:0] pc_wdata_o,
  output logic [AW-1:0] sp_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o
);

  localparam int WORD_BYTES = DW / 8;

  // Named internal events
  seq_state_e        seq_st;
  logic [SLOT_W-1:0] seq_step;
  logic              seq_long;
  logic              seq_last;
  logic              start_push;
  logic              start_pop;
  logic              push_acc;
  logic              pop_acc;
  logic [MODE_W-1:0] cur_mode;
  logic [AW-1:0]     acc_addr;
  logic [DW-1:0]     sr_cap_q;
  logic [DW-1:0]     pc_cap_q;

  assign cur_mode = cur_sr_i[MODE_LSB +: MODE_W];
  assign push_acc = (seq_st == SEQ_PUSH);
  assign pop_acc  = (seq_st == SEQ_POP);
  assign busy_o   = (seq_st != SEQ_IDLE);

  evt_frame_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_i      (enter_i),
    .enter_cls_i  (enter_cls_i),
    .ret_i        (ret_i),
    .cur_mode_i   (cur_mode),
    .st_o         (seq_st),
    .step_o       (seq_step),
    .long_o       (seq_long),
    .last_o       (seq_last),
    .start_push_o (start_push),
    .start_pop_o  (start_pop),
    .done_o       (done_o)
  );

  evt_sp_unit #(
    .AW         (AW),
    .WORD_BYTES (WORD_BYTES),
    .SP_RESET   (SP_RESET)
  ) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_acc),
    .pop_i   (pop_acc),
    .limit_i (sp_limit_i),
    .sp_o    (sp_o),
    .addr_o  (acc_addr),
    .ovf_o   (ovf_o)
  );

  // Context words are frozen at acceptance so the source may move on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_cap_q <= '0;
      pc_cap_q <= '0;
    end else if (start_push) begin
      sr_cap_q <= cur_sr_i;
      pc_cap_q <= cur_pc_i;
    end
  end

  evt_slot_mux #(
    .DW (DW),
    .AW (AW)
  ) u_mux (
    .st_i        (seq_st),
    .step_i      (seq_step),
    .long_i      (seq_long),
    .sr_cap_i    (sr_cap_q),
    .pc_cap_i    (pc_cap_q),
    .rf_rdata_i  (rf_rdata_i),
    .mem_rdata_i (mem_rdata_i),
    .addr_i      (acc_addr),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rf_raddr_o  (rf_raddr_o),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .sr_we_o     (sr_we_o),
    .sr_wdata_o  (sr_wdata_o),
    .pc_we_o     (pc_we_o),
    .pc_wdata_o  (pc_wdata_o)
  );

  // R2: first word written carries the status sampled at acceptance
  a_r2_first_is_sr: assert property (@(posedge clk) disable iff (!rst_n)
    start_push |=> (mem_we_o && mem_wdata_o == $past(cur_sr_i)));

  // R5: first pop reads at the pointer held when the return was taken
  a_r5_first_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_pop |=> (mem_re_o && mem_addr_o == $past(sp_o)));

  // R5: a short frame never restores general registers
  a_r5_short_no_gpr: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !seq_long) |-> !rf_we_o);

  // R5: the status word is the final word popped
  a_r5_sr_last: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(mem_re_o)) |-> $past(sr_we_o));

  // R9: one stack access per cycle
  a_r9_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we_o, mem_re_o}));

  // R9: idle means quiet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mem_we_o || mem_re_o || rf_we_o || sr_we_o || pc_we_o));

endmodule

// File: tb/evt_ctx_seq_tb.sv
module evt_ctx_seq_tb;

  localparam int          MODE_LSB = 22;
  localparam logic [31:0] SP_RST   = 32'h0000_0100;
  localparam int          NV       = 6;
  localparam logic [2:0]  VEC_CLS  [NV] = '{3'd2, 3'd0, 3'd5, 3'd3, 3'd6, 3'd4};
  localparam int          VEC_LEN  [NV] = '{8, 2, 8, 8, 2, 8};
  localparam logic [31:0] VEC_SEED [NV] = '{32'h1000_0001, 32'h2222_0000, 32'h3456_7890,
                                            32'h0BAD_F00D, 32'h7777_0707, 32'hC0DE_0042};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        enter = 1'b0;
  logic [2:0]  enter_cls = '0;
  logic        ret = 1'b0;
  logic [31:0] cur_sr = '0, cur_pc = '0, sp_limit = '0;
  logic        mem_we, mem_re, rf_we, sr_we, pc_we, busy, done, ovf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, sr_wdata, pc_wdata, sp;
  logic [2:0]  rf_raddr, rf_waddr;

  logic [31:0] mem [64];
  logic [31:0] rf_src [8];
  logic [31:0] rf_back [8];
  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];
  logic [31:0] got_sr = '0, got_pc = '0;
  int wcnt = 0, rf_wr_cnt = 0, viol = 0;
  int checks = 0, failures = 0;

  assign mem_rdata = mem[mem_addr[7:2]];
  assign rf_rdata  = rf_src[rf_raddr];

  evt_ctx_seq #(.MODE_LSB(MODE_LSB), .SP_RESET(SP_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .enter_i(enter), .enter_cls_i(enter_cls), .ret_i(ret),
    .cur_sr_i(cur_sr), .cur_pc_i(cur_pc), .sp_limit_i(sp_limit),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .sr_we_o(sr_we), .sr_wdata_o(sr_wdata), .pc_we_o(pc_we), .pc_wdata_o(pc_wdata),
    .sp_o(sp), .busy_o(busy), .done_o(done), .ovf_o(ovf)
  );

  // Stack memory, register file restore side and strobe monitor
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:2]]   <= mem_wdata;
      log_addr[wcnt[7:0]]  <= mem_addr;
      log_data[wcnt[7:0]]  <= mem_wdata;
      wcnt                 <= wcnt + 1;
    end
    if (rf_we) begin
      rf_back[rf_waddr] <= rf_wdata;
      rf_wr_cnt         <= rf_wr_cnt + 1;
    end
    if (sr_we) got_sr <= sr_wdata;
    if (pc_we) got_pc <= pc_wdata;
    if (rst_n && ((mem_we && mem_re) || (!busy && (mem_we || mem_re || rf_we || sr_we || pc_we))))
      viol <= viol + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] with_mode(input logic [31:0] base, input logic [2:0] m);
    return (base & ~(32'h7 << MODE_LSB)) | (32'(m) << MODE_LSB);
  endfunction

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_enter(input logic [2:0] cls, input logic [31:0] sr, input logic [31:0] pc,
                           output int cyc);
    @(negedge clk);
    enter = 1'b1; enter_cls = cls; cur_sr = sr; cur_pc = pc;
    @(negedge clk);
    enter = 1'b0;
    wait_idle(cyc);
  endtask

  task automatic run_ret(input logic [31:0] sr_now, output int cyc);
    @(negedge clk);
    ret = 1'b1; cur_sr = sr_now;
    @(negedge clk);
    ret = 1'b0;
    wait_idle(cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc, bad, bw, br;
    logic [31:0] sp0, sr0, pc0, ed, ea;
    logic [31:0] orig [6];

    for (int k = 0; k < 8; k++) rf_src[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !ovf, "R1", "flags after reset", {29'd0, busy, done, ovf}, 32'd0);
    chk(sp == SP_RST, "R1", "sp after reset", sp, SP_RST);
    chk(!mem_we && !mem_re && !sr_we && !pc_we && !rf_we, "R1", "strobes after reset",
        {27'd0, mem_we, mem_re, sr_we, pc_we, rf_we}, 32'd0);

    // Vector table: push then return for each class
    for (int v = 0; v < NV; v++) begin
      int len;
      len = VEC_LEN[v];
      for (int k = 0; k < 6; k++) begin
        rf_src[k] = VEC_SEED[v] + 32'(k) * 32'h0000_0111;
        orig[k]   = rf_src[k];
      end
      sr0 = VEC_SEED[v] ^ 32'hA5A5_0000;
      pc0 = VEC_SEED[v] ^ 32'h0F0F_1234;
      sp0 = sp; bw = wcnt;
      run_enter(VEC_CLS[v], sr0, pc0, cyc);
      chk(cyc == len, "R7", "push busy cycles", 32'(cyc), 32'(len));
      chk(done == 1'b1, "R7", "done after push", {31'd0, done}, 32'd1);
      bad = 0;
      for (int i = 0; i < len; i++) begin
        ed = (i == 0) ? sr0 : (i == 1) ? pc0 : orig[7 - i];
        ea = sp0 - 32'(4 * (i + 1));
        if (log_addr[8'(bw + i)] != ea || log_data[8'(bw + i)] != ed) bad++;
      end
      if (len == 8) chk(bad == 0 && wcnt - bw == 8, "R2", "long frame words", 32'(wcnt - bw + bad), 32'd8);
      else          chk(bad == 0 && wcnt - bw == 2, "R3", "short frame words", 32'(wcnt - bw + bad), 32'd2);
      chk(sp == sp0 - 32'(4 * len), "R4", "sp after push", sp, sp0 - 32'(4 * len));
      // Change the live registers so the restore must come from the stack
      for (int k = 0; k < 6; k++) rf_src[k] = ~orig[k];
      br = rf_wr_cnt;
      run_ret(with_mode(32'h1357_9BDF, VEC_CLS[v]), cyc);
      chk(cyc == len, "R7", "pop busy cycles", 32'(cyc), 32'(len));
      chk(done == 1'b1, "R7", "done after pop", {31'd0, done}, 32'd1);
      chk(got_sr == sr0, "R5", "restored status", got_sr, sr0);
      chk(got_pc == pc0, "R5", "restored return address", got_pc, pc0);
      if (len == 8) begin
        bad = 0;
        for (int k = 0; k < 6; k++) if (rf_back[k] != orig[k]) bad++;
        chk(bad == 0 && rf_wr_cnt - br == 6, "R5", "register restore", 32'(rf_wr_cnt - br + bad), 32'd6);
      end else begin
        chk(rf_wr_cnt - br == 0, "R5", "short frame leaves registers", 32'(rf_wr_cnt - br), 32'd0);
      end
      chk(sp == sp0, "R4", "sp after pop", sp, sp0);
    end

    // R6: commands while busy are ignored
    sp0 = sp; bw = wcnt;
    @(negedge clk);
    enter = 1'b1; enter_cls = 3'd0; cur_sr = 32'h1111_AAAA; cur_pc = 32'h2222_BBBB;
    @(negedge clk);
    enter = 1'b1; enter_cls = 3'd2; ret = 1'b1; cur_sr = with_mode(32'h0, 3'd2);
    @(negedge clk);
    enter = 1'b0; ret = 1'b0;
    wait_idle(cyc);
    chk(wcnt - bw == 2, "R6", "writes with commands while busy", 32'(wcnt - bw), 32'd2);
    chk(sp == sp0 - 32'd8, "R6", "sp with commands while busy", sp, sp0 - 32'd8);
    chk(log_data[8'(bw)] == 32'h1111_AAAA, "R2", "status sampled at acceptance",
        log_data[8'(bw)], 32'h1111_AAAA);
    run_ret(with_mode(32'h0, 3'd0), cyc);
    chk(sp == sp0, "R6", "sp restored", sp, sp0);

    // R6: enter and return together in idle, enter taken
    bw = wcnt; br = rf_wr_cnt;
    @(negedge clk);
    enter = 1'b1; ret = 1'b1; enter_cls = 3'd7; cur_sr = with_mode(32'h4444_0000, 3'd3);
    cur_pc = 32'h5555_0000;
    @(negedge clk);
    enter = 1'b0; ret = 1'b0;
    wait_idle(cyc);
    chk(wcnt - bw == 2 && sp == sp0 - 32'd8, "R6", "enter wins over return", sp, sp0 - 32'd8);
    run_ret(with_mode(32'h0, 3'd1), cyc);
    chk(sp == sp0, "R4", "sp after short pop", sp, sp0);

    // R8: overflow boundary
    chk(sp == SP_RST && !ovf, "R8", "no overflow before limit test", {31'd0, ovf}, 32'd0);
    sp_limit = 32'h0000_00F0;
    @(negedge clk);
    enter = 1'b1; enter_cls = 3'd4; cur_sr = 32'h0; cur_pc = 32'h0;
    @(negedge clk);
    enter = 1'b0;
    repeat (4) @(negedge clk);
    chk(!ovf, "R8", "target equal to limit", {31'd0, ovf}, 32'd0);
    @(negedge clk);
    chk(ovf, "R8", "target below limit", {31'd0, ovf}, 32'd1);
    wait_idle(cyc);
    run_ret(with_mode(32'h0, 3'd4), cyc);
    chk(ovf, "R8", "overflow sticky", {31'd0, ovf}, 32'd1);
    chk(sp == SP_RST, "R4", "sp back after overflow frame", sp, SP_RST);

    // R9: strobe discipline over the whole run
    chk(viol == 0, "R9", "access exclusivity and idle quiet", 32'(viol), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule